// File: doc/BRIEF.md
# eMMC Bring-Up Command Sequencer

This block takes an eMMC device with an 8-bit data bus from power-up to the high-speed transfer state. It does this without software involvement. After a `start` pulse it walks a fixed list of commands. It hands each command to a separate command engine through a request/acknowledge handshake: a command index, a 32-bit argument, a response kind and a data-read flag. It then inspects the response word the engine returns with the acknowledge.

Along the way the sequencer moves two settings that the physical layer consumes:
- the bus width, from 1 lane to 8 lanes;
- the bus clock divider, from the identification value of 240 to the fast value of 2.

On a 96 MHz source these divider values give 400 kHz and 48 MHz. The device sector count is taken from the extended CSD block as it streams past. The sequencer ends in a done state, or in an error state that holds a code naming the step that failed.

The states, in order, are:
- ST_IDLE
- ST_GO_IDLE (CMD0)
- ST_OP_COND (CMD1, repeated)
- ST_CID (CMD2)
- ST_RCA (CMD3)
- ST_SELECT (CMD7)
- ST_STATUS (CMD13)
- ST_WIDE (CMD6, bus width)
- ST_HSPEED (CMD6, timing)
- ST_EXTCSD (CMD8)
- ST_DONE
- ST_FAIL

The transitions are:
- ST_IDLE leaves on `start`.
- Each command state advances to the next state on an acknowledge whose checks pass.
- ST_OP_COND stays put while the device reports busy and the poll window is still open.
- Any failed check goes to ST_FAIL.
- ST_DONE and ST_FAIL are left only through reset.

Top module: `emmc_bringup_seq`

## Requirements
- R1: After reset the sequencer is in ST_IDLE with the following outputs. `cmd_req`, `done` and `failed` are low. `fail_code` is 0, `clk_div` is 240, `bus_width` is 1, `blk_size_log2` is 9 and `sector_count` is 0.
- R2: On `start`, the first command is CMD0 with argument 0 and response kind 0 (none). It is followed by CMD1 with argument 0x40FF8000 and response kind 1 (short). CMD1 is reissued after every response whose bit 31 is clear, and the sequence moves on once a response has bit 31 set.
- R3: If a CMD1 response with bit 31 clear arrives once POLL_LIMIT clock cycles have passed since ST_OP_COND was entered, the sequencer fails with code 3.
- R4: After CMD1 come three commands in order. CMD2 has argument 0 and response kind 2 (long). CMD3 and CMD7 each have argument 0x00010000 and response kind 1.
- R5: CMD13 is issued with argument 0x00010000. If response bits 12:9 differ from 4, the sequencer fails with code 8.
- R6: CMD6 is issued with argument 0x03B70200. If response bit 7 is set, the sequencer fails with code 10 and `bus_width` stays 1. Otherwise `bus_width` becomes 8 in the cycle after the acknowledge. Until then it is 1.
- R7: CMD6 is issued with argument 0x03B90100. If response bit 7 is set, the sequencer fails with code 12 and `clk_div` stays 240. Otherwise `clk_div` becomes 2.
- R8: CMD8 is issued with argument 0, response kind 1 and `cmd_data_rd` high. Bytes 212..215 of the 512-byte data stream are placed in `sector_count` little-endian, with byte 212 in bits 7:0. `done` then rises.
- R9: If `cmd_err` is high with an acknowledge, the sequence aborts at once with that step's code: CMD0 = 1, CMD1 = 2, CMD2 = 4, CMD3 = 5, CMD7 = 6, CMD13 = 7, first CMD6 = 9, second CMD6 = 11, CMD8 = 13.
- R10: ST_FAIL is sticky. `failed` and `fail_code` hold, no request is raised, and `start` is ignored until reset.
- R11: While `cmd_req` is high and unacknowledged, the index and argument stay stable.
- R12: `cmd_data_rd` is high only while CMD8 is requested. `done` and `failed` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start | input | 1 | Begin the bring-up (honoured in ST_IDLE only) |
| cmd_req | output | 1 | Command request to the engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_type | output | 2 | 0 none, 1 short, 2 long |
| cmd_data_rd | output | 1 | Command carries a one-block data read |
| cmd_ack | input | 1 | Engine completes the current command |
| cmd_err | input | 1 | Engine failure, valid with `cmd_ack` |
| cmd_resp | input | 32 | Response word, valid with `cmd_ack` |
| rd_valid | input | 1 | Data-read byte strobe |
| rd_byte | input | 8 | Data-read byte |
| clk_div | output | DIV_W | Bus clock divider |
| bus_width | output | 4 | Active data lanes |
| blk_size_log2 | output | 4 | Block size as log2 of bytes |
| sector_count | output | 32 | Device sector count |
| done | output | 1 | Bring-up finished |
| failed | output | 1 | Bring-up aborted |
| fail_code | output | 4 | Code of the failing step |

## Verification
The bench looks for five faults, each of which shows at the ports:
- **Polling.** It makes CMD1 report busy for a few rounds and then forever. A design that stops polling early would issue CMD2 out of turn. A design that never times out would hang instead of showing code 3.
- **State check.** It returns a CMD13 state of 3. A design that misreads bits 12:9 would carry on to CMD6.
- **Switch errors.** It sets the switch-error bit on each CMD6 in turn. Bus width or clock divider values that were updated anyway would show on the outputs.
- **Engine errors.** It injects engine errors at the first step, a middle step and the last step. A wrong step code would be reported, or the sector count would be overwritten.
- **Byte order.** Two different sector counts, one with its top bytes all ones, expose a wrong capture order or offset.

// File: rtl/emmc_seq_pkg.sv
package emmc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GO_IDLE, ST_OP_COND, ST_CID, ST_RCA, ST_SELECT,
        ST_STATUS, ST_WIDE, ST_HSPEED, ST_EXTCSD, ST_DONE, ST_FAIL
    } seq_state_e;

    localparam logic [1:0] RSP_NONE  = 2'd0;
    localparam logic [1:0] RSP_SHORT = 2'd1;
    localparam logic [1:0] RSP_LONG  = 2'd2;

    localparam logic [3:0] E_NONE        = 4'd0;
    localparam logic [3:0] E_GO_IDLE     = 4'd1;
    localparam logic [3:0] E_OP_ENGINE   = 4'd2;
    localparam logic [3:0] E_OP_TIMEOUT  = 4'd3;
    localparam logic [3:0] E_CID         = 4'd4;
    localparam logic [3:0] E_RCA         = 4'd5;
    localparam logic [3:0] E_SELECT      = 4'd6;
    localparam logic [3:0] E_STATUS      = 4'd7;
    localparam logic [3:0] E_NOT_TRAN    = 4'd8;
    localparam logic [3:0] E_WIDE        = 4'd9;
    localparam logic [3:0] E_WIDE_SWITCH = 4'd10;
    localparam logic [3:0] E_HS          = 4'd11;
    localparam logic [3:0] E_HS_SWITCH   = 4'd12;
    localparam logic [3:0] E_EXTCSD      = 4'd13;

    localparam logic [31:0] ARG_OP_COND = 32'h40FF_8000;
    localparam logic [31:0] ARG_WIDE8   = 32'h03B7_0200;
    localparam logic [31:0] ARG_HSPEED  = 32'h03B9_0100;
    localparam logic [3:0]  TRAN_STATE  = 4'd4;

    typedef struct packed {
        logic        valid;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  rsp;
        logic        rd;
        logic [3:0]  code;
    } cmd_desc_t;

    function automatic cmd_desc_t cmd_for_state(seq_state_e st, logic [15:0] rca);
        cmd_desc_t d;
        d = '{valid: 1'b1, idx: 6'd0, arg: 32'd0, rsp: RSP_SHORT, rd: 1'b0, code: E_NONE};
        unique case (st)
            ST_GO_IDLE: begin d.rsp = RSP_NONE; d.code = E_GO_IDLE; end
            ST_OP_COND: begin d.idx = 6'd1;  d.arg = ARG_OP_COND; d.code = E_OP_ENGINE; end
            ST_CID:     begin d.idx = 6'd2;  d.rsp = RSP_LONG;    d.code = E_CID; end
            ST_RCA:     begin d.idx = 6'd3;  d.arg = {rca, 16'h0}; d.code = E_RCA; end
            ST_SELECT:  begin d.idx = 6'd7;  d.arg = {rca, 16'h0}; d.code = E_SELECT; end
            ST_STATUS:  begin d.idx = 6'd13; d.arg = {rca, 16'h0}; d.code = E_STATUS; end
            ST_WIDE:    begin d.idx = 6'd6;  d.arg = ARG_WIDE8;   d.code = E_WIDE; end
            ST_HSPEED:  begin d.idx = 6'd6;  d.arg = ARG_HSPEED;  d.code = E_HS; end
            ST_EXTCSD:  begin d.idx = 6'd8;  d.rd = 1'b1;         d.code = E_EXTCSD; end
            default:    begin d.valid = 1'b0; d.rsp = RSP_NONE; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/emmc_poll_timer.sv
module emmc_poll_timer #(
    parameter int LIMIT = 96_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles spent in the polling state, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CNT_MAX);
endmodule

// File: rtl/emmc_extcsd_tap.sv
module emmc_extcsd_tap #(
    parameter int BLOCK_BYTES = 512,
    parameter int OFFSET      = 212,
    parameter int FIELD_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm,
    input  logic                     byte_valid,
    input  logic [7:0]               byte_in,
    output logic [8*FIELD_BYTES-1:0] field
);
    localparam int IDX_W = $clog2(BLOCK_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BLOCK_BYTES);

    logic [IDX_W-1:0] idx_q;

    // Byte position within the block; restarts whenever the tap is disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm)
            idx_q <= '0;
        else if (byte_valid && idx_q != IDX_END)
            idx_q <= idx_q + 1'b1;
    end

    // One lane per field byte: lane g takes byte OFFSET+g (little-endian).
    for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_lane
        localparam logic [IDX_W-1:0] POS = IDX_W'(OFFSET + g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                field[8*g +: 8] <= 8'h00;
            else if (arm && byte_valid && idx_q == POS)
                field[8*g +: 8] <= byte_in;
        end
    end
endmodule

// File: rtl/emmc_bringup_seq.sv
module emmc_bringup_seq
    import emmc_seq_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int CLK_DIV_IDENT = 240,
    parameter int CLK_DIV_FAST  = 2,
    parameter int POLL_LIMIT    = 96_000_000,
    parameter int DEV_ADDR      = 1,
    parameter int BLOCK_BYTES   = 512,
    parameter int SECT_OFFSET   = 212,
    parameter int BLK_LOG2      = 9,
    parameter int WIDE_LANES    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cmd_req,
    output logic [5:0]       cmd_idx,
    output logic [31:0]      cmd_arg,
    output logic [1:0]       cmd_rsp_type,
    output logic             cmd_data_rd,
    input  logic             cmd_ack,
    input  logic             cmd_err,
    input  logic [31:0]      cmd_resp,
    input  logic             rd_valid,
    input  logic [7:0]       rd_byte,
    output logic [DIV_W-1:0] clk_div,
    output logic [3:0]       bus_width,
    output logic [3:0]       blk_size_log2,
    output logic [31:0]      sector_count,
    output logic             done,
    output logic             failed,
    output logic [3:0]       fail_code
);
    localparam logic [15:0]      RCA_VAL   = 16'(DEV_ADDR);
    localparam logic [DIV_W-1:0] DIV_SLOW  = DIV_W'(CLK_DIV_IDENT);
    localparam logic [DIV_W-1:0] DIV_FAST  = DIV_W'(CLK_DIV_FAST);
    localparam logic [3:0]       LANES_ONE = 4'd1;
    localparam logic [3:0]       LANES_ALL = 4'(WIDE_LANES);
    localparam int               SECT_BYTES = 4;

    seq_state_e  state_q, state_d;
    cmd_desc_t   desc;
    logic        handshake;
    logic        poll_expired;
    logic        step_fail;
    logic [3:0]  step_code;
    logic [31:0] csd_field;

    assign desc         = cmd_for_state(state_q, RCA_VAL);
    assign cmd_req      = desc.valid;
    assign cmd_idx      = desc.idx;
    assign cmd_arg      = desc.arg;
    assign cmd_rsp_type = desc.rsp;
    assign cmd_data_rd  = desc.rd;
    assign handshake    = cmd_req && cmd_ack;

    emmc_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_OP_COND),
        .expired (poll_expired)
    );

    emmc_extcsd_tap #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .OFFSET      (SECT_OFFSET),
        .FIELD_BYTES (SECT_BYTES)
    ) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (state_q == ST_EXTCSD),
        .byte_valid (rd_valid),
        .byte_in    (rd_byte),
        .field      (csd_field)
    );

    // Next-state and failure decision.
    always_comb begin
        state_d   = state_q;
        step_fail = 1'b0;
        step_code = E_NONE;
        if (state_q == ST_IDLE) begin
            if (start)
                state_d = ST_GO_IDLE;
        end else if (handshake && cmd_err) begin
            step_fail = 1'b1;
            step_code = desc.code;
        end else if (handshake) begin
            unique case (state_q)
                ST_GO_IDLE: state_d = ST_OP_COND;
                ST_OP_COND: begin
                    if (cmd_resp[31])
                        state_d = ST_CID;
                    else if (poll_expired) begin
                        step_fail = 1'b1;
                        step_code = E_OP_TIMEOUT;
                    end
                end
                ST_CID:     state_d = ST_RCA;
                ST_RCA:     state_d = ST_SELECT;
                ST_SELECT:  state_d = ST_STATUS;
                ST_STATUS: begin
                    if (cmd_resp[12:9] != TRAN_STATE) begin
                        step_fail = 1'b1;
                        step_code = E_NOT_TRAN;
                    end else
                        state_d = ST_WIDE;
                end
                ST_WIDE: begin
                    if (cmd_resp[7]) begin
                        step_fail = 1'b1;
                        step_code = E_WIDE_SWITCH;
                    end else
                        state_d = ST_HSPEED;
                end
                ST_HSPEED: begin
                    if (cmd_resp[7]) begin
                        step_fail = 1'b1;
                        step_code = E_HS_SWITCH;
                    end else
                        state_d = ST_EXTCSD;
                end
                ST_EXTCSD:  state_d = ST_DONE;
                default:    state_d = state_q;
            endcase
        end
        if (step_fail)
            state_d = ST_FAIL;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs, updated on the transitions that own them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_div      <= DIV_SLOW;
            bus_width    <= LANES_ONE;
            sector_count <= 32'd0;
            fail_code    <= E_NONE;
        end else begin
            if (step_fail)
                fail_code <= step_code;
            if (state_q == ST_WIDE && state_d == ST_HSPEED)
                bus_width <= LANES_ALL;
            if (state_q == ST_HSPEED && state_d == ST_EXTCSD)
                clk_div <= DIV_FAST;
            if (state_q == ST_EXTCSD && state_d == ST_DONE)
                sector_count <= csd_field;
        end
    end

    assign blk_size_log2 = 4'(BLK_LOG2);
    assign done          = (state_q == ST_DONE);
    assign failed        = (state_q == ST_FAIL);
endmodule

// File: rtl/emmc_bringup_seq_chk.sv
module emmc_bringup_seq_chk #(
    parameter int DIV_W    = 8,
    parameter int FAST_DIV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_req,
    input logic             cmd_ack,
    input logic [5:0]       cmd_idx,
    input logic [31:0]      cmd_arg,
    input logic             cmd_data_rd,
    input logic [3:0]       bus_width,
    input logic [DIV_W-1:0] clk_div,
    input logic             done,
    input logic             failed,
    input logic [3:0]       fail_code
);
    p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_idx) && $stable(cmd_arg));

    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        failed |=> failed && $stable(fail_code) && !cmd_req);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !cmd_req);

    p_done_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && failed));

    p_rd_only_cmd8_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_data_rd |-> cmd_idx == 6'd8);

    p_width_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_width == 4'd1 || bus_width == 4'd8);

    p_width_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_width) |-> $past(cmd_ack));

    p_fast_needs_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_div == DIV_W'(FAST_DIV) |-> bus_width == 4'd8);
endmodule

bind emmc_bringup_seq emmc_bringup_seq_chk #(
    .DIV_W    (DIV_W),
    .FAST_DIV (CLK_DIV_FAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_req     (cmd_req),
    .cmd_ack     (cmd_ack),
    .cmd_idx     (cmd_idx),
    .cmd_arg     (cmd_arg),
    .cmd_data_rd (cmd_data_rd),
    .bus_width   (bus_width),
    .clk_div     (clk_div),
    .done        (done),
    .failed      (failed),
    .fail_code   (fail_code)
);

// File: tb/emmc_bringup_seq_tb.sv
module emmc_bringup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int POLL       = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_req, cmd_data_rd, cmd_ack, cmd_err, rd_valid, done, failed;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg, cmd_resp, sector_count;
    logic [1:0]  cmd_rsp_type;
    logic [7:0]  rd_byte, clk_div;
    logic [3:0]  bus_width, blk_size_log2, fail_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    emmc_bringup_seq #(.POLL_LIMIT(POLL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_rsp_type(cmd_rsp_type), .cmd_data_rd(cmd_data_rd),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .clk_div(clk_div), .bus_width(bus_width), .blk_size_log2(blk_size_log2),
        .sector_count(sector_count), .done(done), .failed(failed), .fail_code(fail_code)
    );

    typedef struct {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  rsp;
        logic        rd;
        logic [31:0] resp;
        logic        err;
        logic        rep;
        logic [3:0]  width;
        logic [7:0]  div;
        string       tag;
    } exp_cmd_t;

    exp_cmd_t   exp_q[$];
    logic [7:0] ext_img [512];
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cyc = 0;
    int         t_poll = -1;
    bit         finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rsp,
                        input logic rd, input logic [31:0] resp, input logic err, input logic rep,
                        input logic [3:0] w, input logic [7:0] dv, input string tag);
        exp_cmd_t e;
        e = '{idx: idx, arg: arg, rsp: rsp, rd: rd, resp: resp, err: err, rep: rep,
              width: w, div: dv, tag: tag};
        exp_q.push_back(e);
    endtask

    task automatic set_ext(input logic [31:0] sectors);
        for (int i = 0; i < 512; i++) ext_img[i] = 8'(i) ^ 8'hA5;
        for (int b = 0; b < 4; b++) ext_img[212 + b] = sectors[8*b +: 8];
    endtask

    // Pushes CMD0, one ready CMD1, CMD2, CMD3 and CMD7.
    task automatic push_ident();
        push(6'd0, 32'd0, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd1, 32'h40FF8000, 2'd1, 1'b0, 32'h80FF8000, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd2, 32'd0, 2'd2, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
        push(6'd3, 32'h00010000, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
        push(6'd7, 32'h00010000, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
    endtask

    // Scoreboard monitor: acts as the command engine and compares each request.
    initial begin
        cmd_ack = 1'b0; cmd_err = 1'b0; cmd_resp = 32'd0; rd_valid = 1'b0; rd_byte = 8'd0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected command index", 32'(cmd_idx), 32'hFFFFFFFF);
                    cmd_resp = 32'd0; cmd_err = 1'b1;
                end else begin
                    exp_cmd_t e;
                    e = exp_q[0];
                    if (!e.rep) void'(exp_q.pop_front());
                    if (e.idx == 6'd1 && t_poll < 0) t_poll = cyc;
                    chk(cmd_idx == e.idx, e.tag, "command index", 32'(cmd_idx), 32'(e.idx));
                    chk(cmd_arg == e.arg, e.tag, "argument", cmd_arg, e.arg);
                    chk(cmd_rsp_type == e.rsp, e.tag, "response kind", 32'(cmd_rsp_type), 32'(e.rsp));
                    chk(cmd_data_rd == e.rd, "R12", "data-read flag", 32'(cmd_data_rd), 32'(e.rd));
                    chk(bus_width == e.width, "R6", "bus width at request", 32'(bus_width), 32'(e.width));
                    chk(clk_div == e.div, "R7", "divider at request", 32'(clk_div), 32'(e.div));
                    if (e.rd) begin
                        for (int i = 0; i < 512; i++) begin
                            rd_valid = 1'b1; rd_byte = ext_img[i];
                            @(negedge clk);
                        end
                        rd_valid = 1'b0;
                    end
                    cmd_resp = e.resp; cmd_err = e.err;
                end
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0; cmd_err = 1'b0;
            end
        end
    end

    task automatic do_reset();
        exp_q.delete();
        t_poll = -1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n;
        n = 0;
        while (!done && !failed && n < 5000) begin
            @(negedge clk); n++;
        end
        chk(done || failed, req, "sequence finished", 32'(n), 32'd0);
    endtask

    task automatic expect_fail(input string req, input logic [3:0] code);
        wait_end(req);
        @(negedge clk);
        chk(failed && !done, req, "failed flag", 32'({done, failed}), 32'h1);
        chk(fail_code == code, req, "fail code", 32'(fail_code), 32'(code));
    endtask

    task automatic happy(input logic [31:0] sectors, input int busy_polls);
        set_ext(sectors);
        push(6'd0, 32'd0, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        for (int i = 0; i < busy_polls; i++)
            push(6'd1, 32'h40FF8000, 2'd1, 1'b0, 32'h00FF8000, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd1, 32'h40FF8000, 2'd1, 1'b0, 32'h80FF8000, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd2, 32'd0, 2'd2, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
        push(6'd3, 32'h00010000, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
        push(6'd7, 32'h00010000, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R4");
        push(6'd13, 32'h00010000, 2'd1, 1'b0, 32'h00000900, 1'b0, 1'b0, 4'd1, 8'd240, "R5");
        push(6'd6, 32'h03B70200, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R6");
        push(6'd6, 32'h03B90100, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd8, 8'd240, "R7");
        push(6'd8, 32'd0, 2'd1, 1'b1, 32'd0, 1'b0, 1'b0, 4'd8, 8'd2, "R8");
        pulse_start();
        wait_end("R8");
        @(negedge clk);
        chk(done && !failed, "R8", "done flag", 32'({done, failed}), 32'h2);
        chk(sector_count == sectors, "R8", "sector count", sector_count, sectors);
        chk(bus_width == 4'd8, "R6", "final bus width", 32'(bus_width), 32'd8);
        chk(clk_div == 8'd2, "R7", "final divider", 32'(clk_div), 32'd2);
        chk(exp_q.size() == 0, "R2", "all commands issued", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            chk(1'b0, "R1", "watchdog expired", 32'(cyc), 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(!cmd_req && !done && !failed, "R1", "idle outputs", 32'({cmd_req, done, failed}), 32'd0);
        chk(fail_code == 4'd0, "R1", "fail code", 32'(fail_code), 32'd0);
        chk(clk_div == 8'd240, "R1", "divider", 32'(clk_div), 32'd240);
        chk(bus_width == 4'd1, "R1", "bus width", 32'(bus_width), 32'd1);
        chk(blk_size_log2 == 4'd9, "R1", "block size log2", 32'(blk_size_log2), 32'd9);
        chk(sector_count == 32'd0, "R1", "sector count", sector_count, 32'd0);

        // R2, R4..R8: full bring-up with busy polling
        happy(32'h0123_4567, 3);

        // R8: second bring-up, no busy polls, top bytes all ones
        do_reset();
        happy(32'hFFFF_0001, 0);

        // R3: device stays busy until the poll window closes
        do_reset();
        push(6'd0, 32'd0, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd1, 32'h40FF8000, 2'd1, 1'b0, 32'h00FF8000, 1'b0, 1'b1, 4'd1, 8'd240, "R3");
        pulse_start();
        expect_fail("R3", 4'd3);
        chk((cyc - t_poll) >= POLL && (cyc - t_poll) <= POLL + 6, "R3", "timeout window cycles",
            32'(cyc - t_poll), 32'(POLL));
        exp_q.delete();

        // R5: wrong current state, then R10 stickiness
        do_reset();
        push_ident();
        push(6'd13, 32'h00010000, 2'd1, 1'b0, 32'h00000600, 1'b0, 1'b0, 4'd1, 8'd240, "R5");
        pulse_start();
        expect_fail("R5", 4'd8);
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        chk(failed && fail_code == 4'd8, "R10", "sticky failure after start", 32'(fail_code), 32'd8);
        chk(!cmd_req, "R10", "no request while failed", 32'(cmd_req), 32'd0);

        // R6: bus-width switch error
        do_reset();
        push_ident();
        push(6'd13, 32'h00010000, 2'd1, 1'b0, 32'h00000900, 1'b0, 1'b0, 4'd1, 8'd240, "R5");
        push(6'd6, 32'h03B70200, 2'd1, 1'b0, 32'h00000080, 1'b0, 1'b0, 4'd1, 8'd240, "R6");
        pulse_start();
        expect_fail("R6", 4'd10);
        chk(bus_width == 4'd1, "R6", "width kept after switch error", 32'(bus_width), 32'd1);

        // R7: high-speed switch error
        do_reset();
        push_ident();
        push(6'd13, 32'h00010000, 2'd1, 1'b0, 32'h00000900, 1'b0, 1'b0, 4'd1, 8'd240, "R5");
        push(6'd6, 32'h03B70200, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R6");
        push(6'd6, 32'h03B90100, 2'd1, 1'b0, 32'h00000080, 1'b0, 1'b0, 4'd8, 8'd240, "R7");
        pulse_start();
        expect_fail("R7", 4'd12);
        chk(clk_div == 8'd240, "R7", "divider kept after switch error", 32'(clk_div), 32'd240);

        // R9: engine errors at first, middle and last step
        do_reset();
        push(6'd0, 32'd0, 2'd0, 1'b0, 32'd0, 1'b1, 1'b0, 4'd1, 8'd240, "R9");
        pulse_start();
        expect_fail("R9", 4'd1);

        do_reset();
        push(6'd0, 32'd0, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd1, 32'h40FF8000, 2'd1, 1'b0, 32'h80FF8000, 1'b0, 1'b0, 4'd1, 8'd240, "R2");
        push(6'd2, 32'd0, 2'd2, 1'b0, 32'd0, 1'b1, 1'b0, 4'd1, 8'd240, "R9");
        pulse_start();
        expect_fail("R9", 4'd4);

        do_reset();
        set_ext(32'hDEAD_BEEF);
        push_ident();
        push(6'd13, 32'h00010000, 2'd1, 1'b0, 32'h00000900, 1'b0, 1'b0, 4'd1, 8'd240, "R5");
        push(6'd6, 32'h03B70200, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd1, 8'd240, "R6");
        push(6'd6, 32'h03B90100, 2'd1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd8, 8'd240, "R7");
        push(6'd8, 32'd0, 2'd1, 1'b1, 32'd0, 1'b1, 1'b0, 4'd8, 8'd2, "R9");
        pulse_start();
        expect_fail("R9", 4'd13);
        chk(sector_count == 32'd0, "R9", "sector count untouched", sector_count, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule